// File: doc/BRIEF.md
# Sigma-Delta Decimation Chain (divide by 32)

This block takes the multi-bit stream from a fourth-order cascaded sigma-delta modulator, built from two second-order loops with 4-bit quantizers, and reduces its rate by 32. The result is a wider signed sample. The nominal input rate is 4 MHz and the nominal output rate is 125 kHz.

Three stages sit in a fixed series:

- A third-order cascaded integrator-comb decimator divides the rate by 8.
- A short symmetric FIR lifts the passband droop of the comb stage and divides by 2.
- A half-band FIR divides by 2 again.

Each stage fires a one-cycle valid pulse per sample it produces. The next stage acts only on that pulse. The final sum is scaled by a right shift, rounded, and clamped to the output width.

An upstream source drives `in_valid` high for one cycle per modulator sample. Idle cycles between samples are allowed. A downstream consumer captures `out_data` whenever `out_valid` is high.

Top module: `sd_decim_chain`

## Requirements
- R1: After reset, exactly one `out_valid` pulse is produced per 32 accepted input samples. An input sample is accepted on a rising edge with `in_valid` high. The first pulse follows the 32nd accepted sample.
- R2: The comb stage is third order, with a rate change of 8 and a differential delay of 1. Its output k equals the sum over j=0..21 of h[j]·x[8k+7−j]. Here h is three length-8 all-ones sequences convolved together, and samples before reset count as zero. Internal sums use IN_W+9 bit two's-complement arithmetic that wraps, so long full-scale inputs still give correct outputs.
- R3: The droop stage forms −c[2m+1] + 18·c[2m] − c[2m−1] from comb outputs c. It emits one value for every second comb output, first on the 2nd comb output.
- R4: The half-band stage uses the taps −1, 0, 9, 16, 9, 0, −1 on droop-stage outputs p, with the newest sample first. It emits one value for every second p, first on the 2nd. The two zero taps take no adder input.
- R5: A cycle with `in_valid` low changes no filter state. Inserting idle cycles anywhere, with any value on `in_data`, leaves the output sequence unchanged.
- R6: The output equals floor((s + 2^(SHIFT−1)) / 2^SHIFT), with rounding half up, where s is the half-band sum. That value is clamped to the range −2^(OUT_W−1) to 2^(OUT_W−1)−1.
- R7: Synchronous reset clears every integrator, comb delay, tap delay and phase counter, and drives `out_valid` and `out_data` to 0. Samples fed before a reset have no influence on later outputs.
- R8: `out_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High for one cycle per modulator sample |
| in_data | input | IN_W | Signed modulator sample |
| out_valid | output | 1 | One-cycle pulse per decimated sample |
| out_data | output | OUT_W | Signed, rounded and clamped output sample |

## Verification
A fault in the comb stage's phase counter shifts which input samples fall into each output. The sample count of R1 then goes wrong, or a step input gives a step edge at the wrong output index, within the first 32 inputs. A corrupted integrator or a tap delay that never clears shows up in the very next output after a reset. The leftover state adds to an otherwise fresh DC result.

Wrap-around faults in the integrators show up only on long full-scale runs. There the outputs must settle to the clamped limits and stay there. A wrong tap weight or a missing zero-tap skip perturbs the impulse response, which is checked value by value from the first output onward.

// File: rtl/sd_decim_chain.sv
module sd_decim_chain #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 24,
  parameter int SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int CIC_R  = 8;
  localparam int PH_W   = $clog2(CIC_R);
  localparam int CIC_W  = IN_W + 9;
  localparam int COMP_W = CIC_W + 5;
  localparam int HB_W   = COMP_W + 6;
  localparam logic signed [HB_W:0] HALF = (HB_W+1)'(1) <<< (SHIFT - 1);
  localparam logic signed [HB_W:0] MAXV = (HB_W+1)'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [HB_W:0] MINV = -MAXV - (HB_W+1)'(1);

  // comb decimator
  logic [PH_W-1:0] cic_ph;
  logic signed [CIC_W-1:0] i1, i2, i3, d1, d2, d3, cic_q;
  logic cic_v;

  wire signed [CIC_W-1:0] x_ext = CIC_W'(in_data);
  wire signed [CIC_W-1:0] i1_n  = i1 + x_ext;
  wire signed [CIC_W-1:0] i2_n  = i2 + i1_n;
  wire signed [CIC_W-1:0] i3_n  = i3 + i2_n;
  wire signed [CIC_W-1:0] c1    = i3_n - d1;
  wire signed [CIC_W-1:0] c2    = c1 - d2;
  wire signed [CIC_W-1:0] c3    = c2 - d3;

  always_ff @(posedge clk) begin
    if (rst) begin
      cic_ph <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0;
      d1 <= '0; d2 <= '0; d3 <= '0;
      cic_q <= '0;
      cic_v <= 1'b0;
    end else begin
      cic_v <= 1'b0;
      if (in_valid) begin
        i1 <= i1_n;
        i2 <= i2_n;
        i3 <= i3_n;
        cic_ph <= cic_ph + 1'b1;
        if (cic_ph == PH_W'(CIC_R - 1)) begin
          d1 <= i3_n;
          d2 <= c1;
          d3 <= c2;
          cic_q <= c3;
          cic_v <= 1'b1;
        end
      end
    end
  end

  // droop compensation, taps -1 18 -1, decimate by 2
  logic signed [CIC_W-1:0] f1, f2;
  logic f_ph, comp_v;
  logic signed [COMP_W-1:0] comp_q;

  wire signed [COMP_W-1:0] e0 = COMP_W'(cic_q);
  wire signed [COMP_W-1:0] e1 = COMP_W'(f1);
  wire signed [COMP_W-1:0] e2 = COMP_W'(f2);
  wire signed [COMP_W-1:0] comp_sum = (e1 <<< 4) + (e1 <<< 1) - e0 - e2;

  always_ff @(posedge clk) begin
    if (rst) begin
      f1 <= '0; f2 <= '0;
      f_ph <= 1'b0;
      comp_q <= '0;
      comp_v <= 1'b0;
    end else begin
      comp_v <= 1'b0;
      if (cic_v) begin
        f1 <= cic_q;
        f2 <= f1;
        f_ph <= ~f_ph;
        if (f_ph) begin
          comp_q <= comp_sum;
          comp_v <= 1'b1;
        end
      end
    end
  end

  // half-band, taps -1 0 9 16 9 0 -1, decimate by 2
  logic signed [COMP_W-1:0] hd [1:6];
  logic h_ph, hb_v;
  logic signed [HB_W-1:0] hb_q;

  wire signed [HB_W-1:0] hb_a = HB_W'(comp_q) + HB_W'(hd[6]);
  wire signed [HB_W-1:0] hb_b = HB_W'(hd[2]) + HB_W'(hd[4]);
  wire signed [HB_W-1:0] hb_c = HB_W'(hd[3]);
  wire signed [HB_W-1:0] hb_sum = (hb_b <<< 3) + hb_b + (hb_c <<< 4) - hb_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= 6; k++) hd[k] <= '0;
      h_ph <= 1'b0;
      hb_q <= '0;
      hb_v <= 1'b0;
    end else begin
      hb_v <= 1'b0;
      if (comp_v) begin
        hd[1] <= comp_q;
        for (int k = 2; k <= 6; k++) hd[k] <= hd[k-1];
        h_ph <= ~h_ph;
        if (h_ph) begin
          hb_q <= hb_sum;
          hb_v <= 1'b1;
        end
      end
    end
  end

  // round half up, then clamp
  wire signed [HB_W:0] rnd = (HB_W+1)'(hb_q) + HALF;
  wire signed [HB_W:0] shr = rnd >>> SHIFT;
  wire signed [OUT_W-1:0] sat_v = (shr > MAXV) ? OUT_W'(MAXV) :
                                  (shr < MINV) ? OUT_W'(MINV) : OUT_W'(shr);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      out_valid <= hb_v;
      if (hb_v) out_data <= sat_v;
    end
  end

  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5
  cic_from_input_chk: assert property (@(posedge clk) disable iff (rst)
    cic_v |-> $past(in_valid));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(i1) && $stable(i3) && $stable(cic_ph)));
  // R3
  comp_from_cic_chk: assert property (@(posedge clk) disable iff (rst)
    comp_v |-> $past(cic_v));
  // R4
  hb_from_comp_chk: assert property (@(posedge clk) disable iff (rst)
    hb_v |-> $past(comp_v));
  // R1
  out_from_hb_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(hb_v));
endmodule

// File: tb/sd_decim_chain_tb_top.sv
module sd_decim_chain_tb_top;
  localparam int IN_W = 6;
  localparam int OUT_W = 18;
  localparam int SHIFT = 4;
  localparam longint MAXO = (64'sd1 <<< (OUT_W - 1)) - 1;
  localparam longint MINO = -MAXO - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit prev_ov = 1'b0;
  bit pulse_bad = 1'b0;
  int xs[$];
  longint got[$];
  longint hc[22];
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sd_decim_chain #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always @(negedge clk) begin
    if (!rst && out_valid) got.push_back(longint'(out_data));
    if (!rst && out_valid && prev_ov) pulse_bad = 1'b1;
    prev_ov = out_valid;
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finish");
    summary();
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint xg(int k);
    return (k < 0 || k >= xs.size()) ? 0 : longint'(xs[k]);
  endfunction

  function automatic int gen(int mode, int v, int i);
    case (mode)
      0: return v;
      1: return (i == 0) ? v : 0;
      2: return (i % 64) - 32;
      3: begin
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'd63) - 32;
      end
      default: return (i % 2 == 0) ? 31 : -32;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 outputs idle after reset
    chk("R7 out_valid after reset", longint'(out_valid), 0);
    chk("R7 out_data after reset", longint'(out_data), 0);
  endtask

  task automatic feed(int mode, int v, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      int s;
      s = gen(mode, v, i);
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        in_data = IN_W'(i * 7 + 5);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = IN_W'(s);
      xs.push_back(s);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run(string tag, int mode, int v, int n, bit gaps);
    longint cic[$];
    longint cp[$];
    longint ex[$];
    int nm;
    do_reset();
    xs.delete();
    got.delete();
    feed(mode, v, n, gaps);
    repeat (20) @(negedge clk);
    nm = n / 8;
    for (int m = 0; m < nm; m++) begin
      longint a = 0;
      for (int j = 0; j < 22; j++) a += hc[j] * xg(8 * m + 7 - j);
      cic.push_back(a);
    end
    for (int j = 0; j < nm / 2; j++) begin
      longint a;
      a = 18 * cic[2*j] - cic[2*j+1] - ((j > 0) ? cic[2*j-1] : 0);
      cp.push_back(a);
    end
    for (int q = 0; q < nm / 4; q++) begin
      longint s, r;
      longint p[7];
      for (int t = 0; t < 7; t++) p[t] = (2*q + 1 - t >= 0) ? cp[2*q + 1 - t] : 0;
      s = -(p[0] + p[6]) + 9 * (p[2] + p[4]) + 16 * p[3];
      r = (s + (64'sd1 <<< (SHIFT - 1))) >>> SHIFT;
      if (r > MAXO) r = MAXO;
      if (r < MINO) r = MINO;
      ex.push_back(r);
    end
    // R1 one output per 32 accepted inputs
    chk({"R1 count ", tag}, got.size(), ex.size());
    for (int k = 0; k < ex.size() && k < got.size(); k++)
      chk({"R2/R3/R4/R6 sample ", tag}, got[k], ex[k]);
  endtask

  initial begin
    longint b2[15];
    for (int i = 0; i < 15; i++) b2[i] = 0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) b2[i+j] += 1;
    for (int i = 0; i < 22; i++) hc[i] = 0;
    for (int i = 0; i < 15; i++) for (int j = 0; j < 8; j++) hc[i+j] += b2[i];

    run("dc_pos_sat R6", 0, 31, 1024, 1'b0);
    run("dc_neg_sat R6", 0, -32, 1024, 1'b0);
    run("dc_small R2", 0, 3, 256, 1'b0);
    run("impulse R2 R3 R4", 1, 31, 256, 1'b0);
    run("code_sweep", 2, 0, 512, 1'b0);
    run("alternate", 4, 0, 256, 1'b0);
    run("random_gaps R5", 3, 0, 1024, 1'b1);
    // R7 partial run then reset, fresh run must match a clean model
    do_reset();
    feed(0, 31, 45, 1'b0);
    run("after_reset R7", 0, 3, 128, 1'b0);
    // R8
    chk("R8 back-to-back out_valid", longint'(pulse_bad), 0);
    summary();
  end
endmodule